// File: doc/BRIEF.md
# One-Wire Network Command Layer

This block sits between the bit-level timing engine of a one-wire slave and its device-command layer. After every reset/presence cycle it collects an 8-bit network command from eight write slots, least significant bit first. It then carries out that command against a 64-bit identity that arrives on an input port: it sends the identity out, compares it with a sequence from the master, or takes part in the three-slot search arbitration that lets a master enumerate every slave on a shared wire. When a command ends successfully, it raises a select level that hands the wire to the device-command layer until the next reset.

The block keeps two pieces of state for the rest of the slave. The first is a resume flag, which records that this slave was the last one addressed and which survives bus resets. The second is an overdrive flag, which tells the bit layer to use fast slot timing. The bit layer reports each completed slot with a one-cycle strobe and the sampled line level. Before a read slot, this block presents the bit it wants on the wire. The identity is sent from bit 0 upward, so the family byte goes first and the check byte goes last. That check byte is taken as part of the stored identity and is not computed here.

Top module: `owr_rom_layer`

## Requirements
- R1: A reset clears the select level and stops any transmission. The command collector then waits for a fresh 8-bit command. Outside reset, the flags hold their values (after power-on reset, select, overdrive and resume are all 0).
- R2: Each command is taken from eight consecutive write slots, least significant bit first. The ninth slot already belongs to the chosen command.
- R3: Command 33h sends identity bits 0 to 63 in order, one per read slot. It then raises select and clears the resume flag.
- R4: Commands 55h and 69h compare 64 write-slot bits with identity bits 0 to 63. If all 64 agree, select rises and the resume flag is set.
- R5: On the first bit that differs in a match, the block goes silent until the next reset. While silent it never transmits, never selects, clears the resume flag and ignores every later slot, including slots that would spell a command.
- R6: Command F0h runs one triplet per identity bit, from bit 0 upward. In the triplet the slave sends the true bit, then the inverted bit, then reads the master's choice. If all 64 choices agree with the identity, select rises and the resume flag is set.
- R7: In a search, a master choice that differs from the identity bit drops the slave into the silent state of R5, and the resume flag is cleared.
- R8: Command CCh raises select at once and clears the resume flag.
- R9: Command A5h raises select only when the resume flag is 1. When the flag is 0, the slave goes silent.
- R10: Command 3Ch sets overdrive and raises select at once, and clears the resume flag.
- R11: Command 69h sets overdrive as soon as its eighth bit is taken. On a mismatch, overdrive returns to the value it had before the command: a slave already in overdrive stays there.
- R12: A reset marked long clears overdrive. A reset that is not marked long leaves overdrive unchanged.
- R13: Any other command code sends the slave into the silent state until the next reset, with overdrive unchanged.
- R14: The resume flag keeps its value across bus resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| busReset | input | 1 | One-cycle strobe: a reset pulse was detected on the wire |
| longReset | input | 1 | Qualifies busReset: the pulse was long enough to leave overdrive |
| slotStb | input | 1 | One-cycle strobe: a time slot has completed |
| slotBit | input | 1 | Line level sampled in the completed slot |
| romId | input | 64 | Stored identity: family in bits 7:0, serial in 55:8, check byte in 63:56 |
| txActive | output | 1 | The next slot is a read slot driven by this slave |
| txBit | output | 1 | Bit for the next read slot (0 means pull the line low) |
| overdrive | output | 1 | Fast slot timing selected for the bit layer |
| resumeFlag | output | 1 | This slave was the last one addressed |
| devSelect | output | 1 | Device-command layer owns the wire until the next reset |

## Verification
The identity used is asymmetric, so any reversal or inversion of bit order shows up in the read-out and search sequences. Match is tried with an exact sequence, which tells success apart from an off-by-one end of sequence. It is also tried with one bit flipped early, which checks that the slave stays silent for the rest of the slots. Search is run once to completion and once with a losing choice at bit 3; the second run shows that the inverted slot and the drop-out both follow the identity bit. Overdrive-match is tried from standard speed and from overdrive, and short and long resets are alternated, which tells the speed-restore rule apart from a plain clear.

// File: rtl/owr_rom_pkg.sv
package owr_rom_pkg;

  localparam logic [7:0] CMD_READ_ID  = 8'h33;
  localparam logic [7:0] CMD_MATCH    = 8'h55;
  localparam logic [7:0] CMD_SEARCH   = 8'hF0;
  localparam logic [7:0] CMD_SKIP     = 8'hCC;
  localparam logic [7:0] CMD_RESUME   = 8'hA5;
  localparam logic [7:0] CMD_OD_SKIP  = 8'h3C;
  localparam logic [7:0] CMD_OD_MATCH = 8'h69;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL,
    ST_IDLE
  } romState_t;

  typedef struct packed {
    logic clrCnt;
    logic incBit;
    logic shiftCmd;
    logic incPhase;
    logic clrPhase;
  } dpCtrl_t;

endpackage

// File: rtl/owr_rom_dp.sv
module owr_rom_dp
  import owr_rom_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic             slotBit,
  input  logic [ID_W-1:0]  romId,
  output logic [CMD_W-1:0] nextCmd,
  output logic             cmdLast,
  output logic             idBit,
  output logic             idLast,
  output logic [1:0]       phase
);

  localparam int CNT_W = $clog2(ID_W);
  localparam logic [CNT_W-1:0] CMD_END = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] ID_END  = CNT_W'(ID_W - 1);

  logic [CMD_W-1:0] cmdShift;
  logic [CNT_W-1:0] bitIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdShift <= '0;
      bitIdx   <= '0;
      phase    <= 2'd0;
    end else begin
      if (ctrl.shiftCmd) cmdShift <= nextCmd;
      if (ctrl.clrCnt)      bitIdx <= '0;
      else if (ctrl.incBit) bitIdx <= bitIdx + 1'b1;
      if (ctrl.clrPhase)      phase <= 2'd0;
      else if (ctrl.incPhase) phase <= phase + 2'd1;
    end
  end

  // Command bits arrive LSB first, so new bits enter at the top.
  assign nextCmd = {slotBit, cmdShift[CMD_W-1:1]};
  assign cmdLast = (bitIdx == CMD_END);
  assign idLast  = (bitIdx == ID_END);
  assign idBit   = romId[bitIdx];

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.incPhase |-> (phase != 2'd2)); // R6

endmodule

// File: rtl/owr_rom_ctrl.sv
module owr_rom_ctrl
  import owr_rom_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             longReset,
  input  logic             slotStb,
  input  logic             slotBit,
  input  logic [CMD_W-1:0] nextCmd,
  input  logic             cmdLast,
  input  logic             idBit,
  input  logic             idLast,
  input  logic [1:0]       phase,
  output dpCtrl_t          ctrl,
  output logic             txActive,
  output logic             txBit,
  output logic             overdrive,
  output logic             resumeFlag,
  output logic             devSelect
);

  romState_t state;
  logic      prevOd;
  logic      bitMiss;

  assign bitMiss = (slotBit != idBit);

  always_comb begin
    ctrl = '0;
    if (busReset) begin
      ctrl.clrCnt   = 1'b1;
      ctrl.clrPhase = 1'b1;
    end else if (slotStb) begin
      unique case (state)
        ST_CMD: begin
          ctrl.shiftCmd = 1'b1;
          if (cmdLast) ctrl.clrCnt = 1'b1;
          else         ctrl.incBit = 1'b1;
        end
        ST_READ:  if (!idLast) ctrl.incBit = 1'b1;
        ST_MATCH: ctrl.incBit = 1'b1;
        ST_SEARCH: begin
          if (phase == 2'd2) begin
            ctrl.clrPhase = 1'b1;
            ctrl.incBit   = 1'b1;
          end else begin
            ctrl.incPhase = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_CMD;
      overdrive  <= 1'b0;
      resumeFlag <= 1'b0;
      prevOd     <= 1'b0;
    end else if (busReset) begin
      state <= ST_CMD;
      if (longReset) overdrive <= 1'b0;
    end else if (slotStb) begin
      unique case (state)
        ST_CMD: if (cmdLast) begin
          unique case (nextCmd)
            CMD_READ_ID: begin
              state      <= ST_READ;
              resumeFlag <= 1'b0;
            end
            CMD_MATCH: begin
              state  <= ST_MATCH;
              prevOd <= overdrive;
            end
            CMD_OD_MATCH: begin
              state     <= ST_MATCH;
              prevOd    <= overdrive;
              overdrive <= 1'b1;
            end
            CMD_SEARCH: begin
              state  <= ST_SEARCH;
              prevOd <= overdrive;
            end
            CMD_SKIP: begin
              state      <= ST_SEL;
              resumeFlag <= 1'b0;
            end
            CMD_OD_SKIP: begin
              state      <= ST_SEL;
              resumeFlag <= 1'b0;
              overdrive  <= 1'b1;
            end
            CMD_RESUME: state <= resumeFlag ? ST_SEL : ST_IDLE;
            default:    state <= ST_IDLE;
          endcase
        end
        ST_READ: if (idLast) state <= ST_SEL;
        ST_MATCH: begin
          if (bitMiss) begin
            state      <= ST_IDLE;
            resumeFlag <= 1'b0;
            overdrive  <= prevOd;
          end else if (idLast) begin
            state      <= ST_SEL;
            resumeFlag <= 1'b1;
          end
        end
        ST_SEARCH: if (phase == 2'd2) begin
          if (bitMiss) begin
            state      <= ST_IDLE;
            resumeFlag <= 1'b0;
          end else if (idLast) begin
            state      <= ST_SEL;
            resumeFlag <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign txActive  = (state == ST_READ) || ((state == ST_SEARCH) && (phase != 2'd2));
  assign txBit     = !txActive ? 1'b1 :
                     ((state == ST_SEARCH) && (phase == 2'd1)) ? ~idBit : idBit;
  assign devSelect = (state == ST_SEL);

  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!devSelect && !txActive)); // R1
  AST_RESUME_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (resumeFlag == $past(resumeFlag))); // R14
  AST_LONG_RESET_STD: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && longReset) |=> !overdrive); // R12
  AST_SHORT_RESET_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !longReset) |=> (overdrive == $past(overdrive))); // R12
  AST_RESUME_ON_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resumeFlag) |-> devSelect); // R4
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !busReset) |=> ((state == ST_IDLE) && !txActive && !devSelect)); // R5
  AST_RESUME_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CMD) && slotStb && cmdLast && (nextCmd == CMD_RESUME) && !resumeFlag && !busReset)
      |=> !devSelect); // R9

endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_rom_pkg::*;
#(
  parameter int ID_W  = 64,
  parameter int CMD_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReset,
  input  logic            longReset,
  input  logic            slotStb,
  input  logic            slotBit,
  input  logic [ID_W-1:0] romId,
  output logic            txActive,
  output logic            txBit,
  output logic            overdrive,
  output logic            resumeFlag,
  output logic            devSelect
);

  dpCtrl_t          ctrl;
  logic [CMD_W-1:0] nextCmd;
  logic             cmdLast;
  logic             idBit;
  logic             idLast;
  logic [1:0]       phase;

  owr_rom_dp #(.ID_W(ID_W), .CMD_W(CMD_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .slotBit(slotBit), .romId(romId),
    .nextCmd(nextCmd), .cmdLast(cmdLast), .idBit(idBit), .idLast(idLast), .phase(phase)
  );

  owr_rom_ctrl #(.CMD_W(CMD_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .longReset(longReset),
    .slotStb(slotStb), .slotBit(slotBit), .nextCmd(nextCmd), .cmdLast(cmdLast),
    .idBit(idBit), .idLast(idLast), .phase(phase), .ctrl(ctrl),
    .txActive(txActive), .txBit(txBit), .overdrive(overdrive),
    .resumeFlag(resumeFlag), .devSelect(devSelect)
  );

endmodule

// File: tb/owr_rom_layer_tb.sv
module owr_rom_layer_tb_top;

  localparam logic [63:0] ID = 64'h3D_9ABC_5678_1234_A2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, longReset = 1'b0, slotStb = 1'b0, slotBit = 1'b0;
  logic txActive, txBit, overdrive, resumeFlag, devSelect;
  logic rdSlot = 1'b0;
  logic expQ[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  owr_rom_layer dut_i (
    .clk(clk), .rstN(rstN), .busReset(busReset), .longReset(longReset),
    .slotStb(slotStb), .slotBit(slotBit), .romId(ID),
    .txActive(txActive), .txBit(txBit), .overdrive(overdrive),
    .resumeFlag(resumeFlag), .devSelect(devSelect)
  );

  // Monitor: each read slot is compared with the bit the driver queued.
  always @(negedge clk) begin
    #1;
    if (slotStb && rdSlot) begin
      logic e;
      e = (expQ.size() > 0) ? expQ.pop_front() : 1'b1;
      compared++;
      if (!(txActive && txBit == e)) begin
        mismatched++;
        $display("FAIL R3/R6 read slot: actual active=%0b bit=%0b expected active=1 bit=%0b",
                 txActive, txBit, e);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    #1;
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulseReset(input bit isLong);
    @(negedge clk); busReset = 1'b1; longReset = isLong;
    @(negedge clk); busReset = 1'b0; longReset = 1'b0;
  endtask

  task automatic wrSlot(input logic b);
    @(negedge clk); slotStb = 1'b1; slotBit = b; rdSlot = 1'b0;
    @(negedge clk); slotStb = 1'b0;
  endtask

  task automatic rdSlotExp(input logic e);
    expQ.push_back(e);
    @(negedge clk); slotStb = 1'b1; slotBit = 1'b1; rdSlot = 1'b1;
    @(negedge clk); slotStb = 1'b0; rdSlot = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wrSlot(c[i]);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({devSelect, overdrive, resumeFlag, txActive} == 4'b0, "R1 power-on state",
          {devSelect, overdrive, resumeFlag, txActive}, 0);
    rstN = 1'b1;

    // Read identity
    pulseReset(1'b1);
    sendCmd(8'h33);
    check(txActive == 1'b1, "R2 read starts after eighth slot", txActive, 1);
    for (int i = 0; i < 64; i++) rdSlotExp(ID[i]);
    check(devSelect && !resumeFlag, "R3 read identity selects, resume 0",
          {devSelect, resumeFlag}, 2'b10);

    // Exact match
    pulseReset(1'b0);
    check(!devSelect && !txActive, "R1 reset drops select", devSelect, 0);
    sendCmd(8'h55);
    for (int i = 0; i < 64; i++) wrSlot(ID[i]);
    check(devSelect && resumeFlag, "R4 match selects and sets resume",
          {devSelect, resumeFlag}, 2'b11);

    // Resume with flag set
    pulseReset(1'b0);
    check(resumeFlag == 1'b1, "R14 resume flag kept over reset", resumeFlag, 1);
    sendCmd(8'hA5);
    check(devSelect == 1'b1, "R9 resume with flag selects", devSelect, 1);

    // Match with bit 5 flipped
    pulseReset(1'b0);
    sendCmd(8'h55);
    for (int i = 0; i < 16; i++) wrSlot(i == 5 ? ~ID[i] : ID[i]);
    check(!devSelect && !resumeFlag && !txActive, "R5 mismatch silent, resume 0",
          {devSelect, resumeFlag, txActive}, 0);
    sendCmd(8'hCC);
    check(!devSelect, "R5 silent ignores later slots", devSelect, 0);

    // Resume with flag clear
    pulseReset(1'b0);
    sendCmd(8'hA5);
    check(!devSelect, "R9 resume without flag stays unselected", devSelect, 0);
    sendCmd(8'hCC);
    check(!devSelect, "R9 resume without flag goes silent", devSelect, 0);

    // Full search
    pulseReset(1'b0);
    sendCmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rdSlotExp(ID[i]);
      rdSlotExp(~ID[i]);
      wrSlot(ID[i]);
    end
    check(devSelect && resumeFlag, "R6 search completes, resume 1",
          {devSelect, resumeFlag}, 2'b11);

    // Skip clears resume
    pulseReset(1'b0);
    sendCmd(8'hCC);
    check(devSelect && !resumeFlag, "R8 skip selects, resume 0",
          {devSelect, resumeFlag}, 2'b10);

    // Search lost at bit 3
    pulseReset(1'b0);
    sendCmd(8'h55);
    for (int i = 0; i < 64; i++) wrSlot(ID[i]);
    pulseReset(1'b0);
    sendCmd(8'hF0);
    for (int i = 0; i < 4; i++) begin
      rdSlotExp(ID[i]);
      rdSlotExp(~ID[i]);
      wrSlot(i == 3 ? ~ID[i] : ID[i]);
    end
    check(!devSelect && !txActive && !resumeFlag, "R7 search drop-out",
          {devSelect, txActive, resumeFlag}, 0);
    wrSlot(1'b1);
    check(!txActive, "R7 dropped slave stays quiet", txActive, 0);

    // Unknown code
    pulseReset(1'b1);
    sendCmd(8'h5A);
    check(!devSelect && !txActive, "R13 unknown code silent", {devSelect, txActive}, 0);
    sendCmd(8'h3C);
    check(!overdrive && !devSelect, "R13 silent ignores overdrive-skip",
          {overdrive, devSelect}, 0);

    // Overdrive-skip, short and long reset
    pulseReset(1'b0);
    sendCmd(8'h3C);
    check(overdrive && devSelect, "R10 overdrive-skip", {overdrive, devSelect}, 2'b11);
    pulseReset(1'b0);
    check(overdrive == 1'b1, "R12 short reset keeps overdrive", overdrive, 1);
    pulseReset(1'b1);
    check(overdrive == 1'b0, "R12 long reset clears overdrive", overdrive, 0);

    // Overdrive-match from standard speed, mismatch
    pulseReset(1'b0);
    sendCmd(8'h69);
    check(overdrive == 1'b1, "R11 overdrive set after command", overdrive, 1);
    wrSlot(~ID[0]);
    check(!overdrive && !devSelect, "R11 mismatch returns to standard",
          {overdrive, devSelect}, 0);

    // Overdrive-match from overdrive, mismatch
    pulseReset(1'b0);
    sendCmd(8'h3C);
    pulseReset(1'b0);
    sendCmd(8'h69);
    wrSlot(ID[0]);
    wrSlot(~ID[1]);
    check(overdrive && !devSelect, "R11 mismatch keeps prior overdrive",
          {overdrive, devSelect}, 2'b10);

    // Overdrive-match success
    pulseReset(1'b1);
    sendCmd(8'h69);
    for (int i = 0; i < 64; i++) wrSlot(ID[i]);
    check(overdrive && devSelect && resumeFlag, "R4 overdrive-match selects",
          {overdrive, devSelect, resumeFlag}, 3'b111);

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule